// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block sits on the host side of a parallel peripheral link. It collects one byte from the peripheral over four status lines. Each byte arrives as two 4-bit halves, and each half is carried by its own interlocked handshake. The host paces the exchange with a hold output. The peripheral answers with an active-low strobe.

After each transfer the block rebuilds the byte, low half first, and offers it on a valid/ready output. It does not start a new byte until the consumer has taken the previous one.

The wait for each strobe edge is guarded by a programmable cycle limit. An overrun raises a sticky timeout flag, drops the partial byte and returns the link to its resting state. A mode output tells the peripheral that the host is running a transfer mode.

Top module: `nib_rev_rx`

## Requirements
- R1: Out of reset the block holds the link at rest: `host_hold_o` is 1, `byte_valid_o` is 0, `timeout_o` is 0 and `mode_on_o` is 0.
- R2: `mode_on_o` follows `enable_i` with a delay of one clock.
- R3: `host_hold_o` is driven low (ready for a half-byte) only while `enable_i` is 1. It returns high once the half-byte has been captured, which is one clock after the synchronized strobe is seen low.
- R4: The status lines map onto the half-byte as follows: `st_fault_n_i` carries bit 0 (then bit 4), `st_select_i` carries bit 1 (then bit 5), `st_paper_i` carries bit 2 (then bit 6) and `st_busy_i` carries bit 3 (then bit 7).
- R5: The first handshake of a byte delivers bits 3:0. The second delivers bits 7:4.
- R6: The hold output is not lowered for the next half-byte until the peripheral strobe has been seen high again.
- R7: A completed byte stays on `byte_o` with `byte_valid_o` at 1, unchanged, until `byte_ready_i` is 1 at a clock edge. While a byte is pending, `host_hold_o` stays high.
- R8: If a wait for a strobe edge lasts more than `wait_limit_i` cycles, the block does three things: it sets `timeout_o`, returns `host_hold_o` high, and discards the partial byte. The next byte then starts again from its low half.
- R9: `timeout_o` stays 1 until `enable_i` goes low. A `wait_limit_i` of 0 turns the timeout off.
- R10: When `enable_i` goes low in the middle of a transfer, `host_hold_o` is high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Transfer mode enabled |
| wait_limit_i | input | CNT_W | Wait limit in cycles; 0 disables the timeout |
| periph_strobe_n_i | input | 1 | Peripheral strobe; low marks a valid half-byte |
| st_fault_n_i | input | 1 | Status line carrying data bit 0 / 4 |
| st_select_i | input | 1 | Status line carrying data bit 1 / 5 |
| st_paper_i | input | 1 | Status line carrying data bit 2 / 6 |
| st_busy_i | input | 1 | Status line carrying data bit 3 / 7 |
| host_hold_o | output | 1 | Host handshake; low = ready for a half-byte |
| mode_on_o | output | 1 | High while the transfer mode is on |
| byte_o | output | 8 | Assembled byte |
| byte_valid_o | output | 1 | Byte available |
| byte_ready_i | input | 1 | Consumer takes the byte |
| timeout_o | output | 1 | Sticky wait-overrun flag |

## Verification
A table of bytes is sent through a reactive peripheral model. The table has different low and high halves (A5/5A, 3C/C3), single set bits at each end (01, 80) and all-ones and all-zeros. Together these separate a swapped half order, a wrong line-to-bit mapping and stuck bits.

Some vectors keep the strobe low for a long time after the first half-byte. This shows whether the host starts the second half-byte before the strobe has returned high.

Separate tests cover the following cases:
- a byte left unaccepted, to show back-pressure;
- a strobe that never falls and a strobe that never rises, to show the timeout and that the partial byte is discarded;
- a limit of zero;
- dropping the enable in the middle of a handshake.

// File: rtl/nib_rev_pkg.sv
package nib_rev_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_LOW  = 2'd1,
    ST_CAPTURE   = 2'd2,
    ST_WAIT_HIGH = 2'd3
  } hs_state_e;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  // Route the four status lines to nibble bit positions (R4)
  function automatic logic [NIB_W-1:0] gather_nibble(input logic fault_n,
                                                     input logic select,
                                                     input logic paper,
                                                     input logic busy);
    logic [NIB_W-1:0] n;
    n[0] = fault_n;
    n[1] = select;
    n[2] = paper;
    n[3] = busy;
    return n;
  endfunction

  // First nibble is the low half (R5)
  function automatic logic [BYTE_W-1:0] join_byte(input logic [NIB_W-1:0] lo,
                                                  input logic [NIB_W-1:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL[g]}};
      else if (STAGES == 1) sh_q <= d_i[g];
      else sh_q <= {sh_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/nib_hs_fsm.sv
module nib_hs_fsm
  import nib_rev_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             strobe_s_i,
  input  logic             pending_i,
  output logic             hold_o,
  output logic             cap_lo_o,
  output logic             cap_hi_o,
  output logic             timeout_o,
  output logic             hi_phase_o
);

  hs_state_e        state_q, state_d;
  logic             hold_q, hold_d;
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_q;
  logic             expire;
  logic             to_evt;

  function automatic logic wait_over(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] lim);
    return (lim != '0) && (cnt >= lim);
  endfunction

  assign expire = wait_over(cnt_q, limit_i);

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    phase_d = phase_q;
    to_evt  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (enable_i && !pending_i && strobe_s_i) begin
          state_d = ST_WAIT_LOW;
          hold_d  = 1'b0;
          phase_d = 1'b0;
        end
      end
      ST_WAIT_LOW: begin
        if (!strobe_s_i) begin
          state_d = ST_CAPTURE;
        end else if (expire) begin
          state_d = ST_IDLE;
          hold_d  = 1'b1;
          phase_d = 1'b0;
          to_evt  = 1'b1;
        end
      end
      ST_CAPTURE: begin
        state_d = ST_WAIT_HIGH;
        hold_d  = 1'b1;
      end
      ST_WAIT_HIGH: begin
        if (strobe_s_i) begin
          if (!phase_q) begin
            state_d = ST_WAIT_LOW;
            hold_d  = 1'b0;
            phase_d = 1'b1;
          end else begin
            state_d = ST_IDLE;
            phase_d = 1'b0;
          end
        end else if (expire) begin
          state_d = ST_IDLE;
          hold_d  = 1'b1;
          phase_d = 1'b0;
          to_evt  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        hold_d  = 1'b1;
      end
    endcase
    if (!enable_i) begin
      state_d = ST_IDLE;
      hold_d  = 1'b1;
      phase_d = 1'b0;
      to_evt  = 1'b0;
    end
  end

  always_comb begin
    if (state_d != state_q) cnt_d = '0;
    else if ((state_q == ST_WAIT_LOW || state_q == ST_WAIT_HIGH) && cnt_q != '1)
      cnt_d = cnt_q + 1'b1;
    else cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b1;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (!enable_i) to_q <= 1'b0;
      else if (to_evt) to_q <= 1'b1;
    end
  end

  assign cap_lo_o   = (state_q == ST_CAPTURE) && !phase_q && enable_i;
  assign cap_hi_o   = (state_q == ST_CAPTURE) &&  phase_q && enable_i;
  assign hold_o     = hold_q;
  assign timeout_o  = to_q;
  assign hi_phase_o = phase_q;

  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> hold_q);

  // R6
  interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(strobe_s_i));

  // R3
  lower_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(enable_i));

endmodule

// File: rtl/nib_pack.sv
module nib_pack
  import nib_rev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              ready_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);

  logic [NIB_W-1:0]  lo_q;
  logic [BYTE_W-1:0] byte_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cap_lo_i) lo_q <= nib_i;
      if (cap_hi_i) begin
        byte_q  <= join_byte(lo_q, nib_i);
        valid_q <= 1'b1;
      end else if (valid_q && ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;

  // R7
  byte_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(byte_q)));

endmodule

// File: rtl/nib_rev_rx.sv
module nib_rev_rx
  import nib_rev_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] wait_limit_i,
  input  logic             periph_strobe_n_i,
  input  logic             st_fault_n_i,
  input  logic             st_select_i,
  input  logic             st_paper_i,
  input  logic             st_busy_i,
  output logic             host_hold_o,
  output logic             mode_on_o,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  input  logic             byte_ready_i,
  output logic             timeout_o
);

  localparam int LINES = NIB_W + 1;
  localparam logic [LINES-1:0] SYNC_RST = {1'b1, {NIB_W{1'b0}}};

  logic [LINES-1:0] raw_w, sync_w;
  logic             strobe_s;
  logic [NIB_W-1:0] nib_s;
  logic             cap_lo, cap_hi, cap_evt, hi_phase;
  logic             mode_q;

  assign raw_w = {periph_strobe_n_i,
                  gather_nibble(st_fault_n_i, st_select_i, st_paper_i, st_busy_i)};

  nib_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_w),
    .q_o  (sync_w)
  );

  assign strobe_s = sync_w[NIB_W];
  assign nib_s    = sync_w[NIB_W-1:0];

  nib_hs_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .limit_i   (wait_limit_i),
    .strobe_s_i(strobe_s),
    .pending_i (byte_valid_o),
    .hold_o    (host_hold_o),
    .cap_lo_o  (cap_lo),
    .cap_hi_o  (cap_hi),
    .timeout_o (timeout_o),
    .hi_phase_o(hi_phase)
  );

  nib_pack i_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_lo_i(cap_lo),
    .cap_hi_i(cap_hi),
    .nib_i   (nib_s),
    .ready_i (byte_ready_i),
    .byte_o  (byte_o),
    .valid_o (byte_valid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else mode_q <= enable_i;
  end
  assign mode_on_o = mode_q;

  assign cap_evt = cap_lo | cap_hi;

  // R7
  no_lower_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> host_hold_o);

  // R3
  capture_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> !host_hold_o);

  // R8
  timeout_rests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> host_hold_o);

  // R5
  byte_after_high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid_o) |-> $past(hi_phase));

endmodule

// File: tb/test_nib_rev_rx.sv
module test_nib_rev_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0;
  logic [15:0] wait_limit_i = '0;
  logic        periph_strobe_n_i = 1'b1;
  logic        st_fault_n_i = 1'b0, st_select_i = 1'b0, st_paper_i = 1'b0, st_busy_i = 1'b0;
  logic        host_hold_o, mode_on_o, byte_valid_o, timeout_o;
  logic        byte_ready_i = 1'b0;
  logic [7:0]  byte_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nib_rev_rx i_nib_rev_rx (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .wait_limit_i(wait_limit_i),
    .periph_strobe_n_i(periph_strobe_n_i), .st_fault_n_i(st_fault_n_i),
    .st_select_i(st_select_i), .st_paper_i(st_paper_i), .st_busy_i(st_busy_i),
    .host_hold_o(host_hold_o), .mode_on_o(mode_on_o), .byte_o(byte_o),
    .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i), .timeout_o(timeout_o)
  );

  // {byte, stall cycles after the low half}
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {8'hA5, 8'd0}, {8'h5A, 8'd12}, {8'h01, 8'd0}, {8'h80, 8'd3},
    {8'hFF, 8'd0}, {8'h00, 8'd20}, {8'h3C, 8'd0}, {8'hC3, 8'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic wait_hold(input logic v);
    int n = 0;
    while (host_hold_o !== v && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // R4: line k of the status group carries bit k of the half-byte
  task automatic put_nib(input logic [3:0] n);
    st_fault_n_i = n[0];
    st_select_i  = n[1];
    st_paper_i   = n[2];
    st_busy_i    = n[3];
  endtask

  task automatic send_byte(input logic [7:0] b, input int stall);
    for (int h = 0; h < 2; h++) begin
      wait_hold(1'b0);
      put_nib(h == 0 ? b[3:0] : b[7:4]);
      @(negedge clk);
      periph_strobe_n_i = 1'b0;
      wait_hold(1'b1);
      if (h == 0 && stall > 0) begin
        bit held = 1'b1;
        for (int k = 0; k < stall; k++) begin
          @(negedge clk);
          if (host_hold_o !== 1'b1) held = 1'b0;
        end
        chk(held, "R6 hold stays high while strobe low", held, 1);
      end
      @(negedge clk);
      periph_strobe_n_i = 1'b1;
    end
  endtask

  task automatic accept();
    byte_ready_i = 1'b1;
    @(negedge clk);
    byte_ready_i = 1'b0;
    chk(byte_valid_o === 1'b0, "R7 valid drops after ready", byte_valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(host_hold_o === 1'b1, "R1 hold at reset", host_hold_o, 1);
    chk(byte_valid_o === 1'b0, "R1 valid at reset", byte_valid_o, 0);
    chk(timeout_o === 1'b0, "R1 timeout at reset", timeout_o, 0);
    chk(mode_on_o === 1'b0, "R1 mode at reset", mode_on_o, 0);

    // R2
    enable_i = 1'b1;
    @(negedge clk);
    chk(mode_on_o === 1'b1, "R2 mode follows enable", mode_on_o, 1);

    // R3 R4 R5 R6 R7: table of bytes
    for (int i = 0; i < NV; i++) begin
      send_byte(VEC[i][15:8], int'(VEC[i][7:0]));
      chk(byte_valid_o === 1'b1, "R3 byte completes", byte_valid_o, 1);
      chk(byte_o === VEC[i][15:8], "R5 R4 assembled byte", byte_o, VEC[i][15:8]);
      accept();
    end

    // R7 back-pressure
    send_byte(8'h42, 0);
    begin
      bit ok = 1'b1;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (host_hold_o !== 1'b1 || byte_valid_o !== 1'b1 || byte_o !== 8'h42) ok = 1'b0;
      end
      chk(ok, "R7 pending byte held, hold high", byte_o, 8'h42);
    end
    accept();
    repeat (2) @(negedge clk);
    chk(host_hold_o === 1'b0, "R3 hold lowers after accept", host_hold_o, 0);

    // R10 enable drop mid-handshake
    enable_i = 1'b0;
    @(negedge clk);
    chk(host_hold_o === 1'b1, "R10 hold high after disable", host_hold_o, 1);
    repeat (3) @(negedge clk);
    chk(mode_on_o === 1'b0, "R2 mode off", mode_on_o, 0);

    // R8 strobe never falls
    wait_limit_i = 16'd8;
    enable_i = 1'b1;
    repeat (30) @(negedge clk);
    chk(timeout_o === 1'b1, "R8 timeout on missing strobe", timeout_o, 1);
    chk(byte_valid_o === 1'b0, "R8 no byte on timeout", byte_valid_o, 0);
    repeat (10) @(negedge clk);
    chk(timeout_o === 1'b1, "R9 timeout sticky", timeout_o, 1);
    enable_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(timeout_o === 1'b0, "R9 timeout cleared by disable", timeout_o, 0);

    // R8 strobe never rises after the low half: partial discarded
    enable_i = 1'b1;
    wait_hold(1'b0);
    put_nib(4'h7);
    @(negedge clk);
    periph_strobe_n_i = 1'b0;
    wait_hold(1'b1);
    repeat (30) @(negedge clk);
    chk(timeout_o === 1'b1, "R8 timeout on stuck strobe", timeout_o, 1);
    chk(host_hold_o === 1'b1, "R8 hold high after timeout", host_hold_o, 1);
    enable_i = 1'b0;
    @(negedge clk);
    periph_strobe_n_i = 1'b1;
    repeat (3) @(negedge clk);
    wait_limit_i = '0;
    enable_i = 1'b1;
    send_byte(8'h96, 40);
    chk(byte_o === 8'h96, "R8 partial half discarded", byte_o, 8'h96);
    chk(timeout_o === 1'b0, "R9 limit zero disables timeout", timeout_o, 0);
    accept();

    summary();
    $finish;
  end

endmodule